// File: doc/BRIEF.md
# DMA Write Transaction Type Selector

This block sits on the output path of an accelerator. It takes write requests and turns each one into a sequence of memory write transactions. A request carries a byte address, a byte length and a request class. The four classes are status block, completion word, parameter block and output data. The block cuts the request at cache-line boundaries and issues one transaction for each piece, in ascending address order.

Each piece is tagged with a write kind: partial write, full-line write or cache-inject line write. The kind is chosen by a small policy register, which holds a separate mode field for each request class. The policies cover three cases:
- detecting that a block ends exactly at the end of a line;
- padding the unused tail of an aligned line;
- repeating an 8-byte completion word across a whole line.

Requests and transactions each use a valid/ready handshake. A new request is taken only after the last piece of the current one has been accepted downstream.

Top module: `dma_wr_kind_sel`

## Requirements
- R1: After reset `txnValid` is 0, `reqReady` is 1 and every policy field is 0. The policy register is written whole when `cfgWrEn` is 1. Its layout is: bits [1:0] status mode, bits [3:2] completion mode, bits [5:4] parameter mode, bit [6] output mode.
- R2: A request is split at 128-byte line boundaries into pieces issued in ascending address order. A partial piece reports its own start address and byte count, and never crosses a line boundary.
- R3: Write kinds are encoded on `txnKind` as 0 = partial, 1 = full line, 2 = cache-inject line. Request classes on `reqClass` are 0 = status, 1 = completion, 2 = parameter, 3 = output. The status mode behaves as follows:
  - 0: always partial.
  - 1: inject when the piece ends at the end of its line, otherwise partial.
  - 2: full line when the piece ends at the end of its line, otherwise partial.
- R4: The completion mode behaves as follows, with `txnRep` = 1 exactly for modes 1 and 2:
  - 0: partial.
  - 1: inject with the word replicated across the line.
  - 2: full line with the word replicated across the line.
- R5: Parameter mode 0 gives a full line when the piece covers a whole aligned 128-byte line, otherwise partial. Parameter mode 1 gives a full line for any piece that starts on a line boundary, otherwise partial.
- R6: Parameter mode 2 gives inject only for a whole aligned 128-byte piece, otherwise partial. Parameter mode 3 gives inject for any piece that starts on a line boundary, otherwise partial.
- R7: Output mode 0 gives a full line for a whole aligned 128-byte piece, otherwise partial. Output mode 1 gives inject for such a piece, otherwise partial.
- R8: A full or inject transaction carries the line base address and a byte count of 128. `txnPad` is 1 exactly when such a line transaction covers fewer real bytes than 128 and is not a replication. `txnPad` is 0 on partial writes.
- R9: The reserved value 3 in the status mode or the completion mode behaves as mode 0 (partial).
- R10: `txnValid` and every transaction field hold steady until `txnReady` is seen. `reqReady` stays 0 from the accept of a request until its last piece has been taken.
- R11: The policy in force when a request is accepted governs all of that request's pieces. A policy write made while the request is in flight has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Policy register write strobe |
| cfgWrData | input | 7 | Policy register write value |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Request accepted this cycle when high with `reqValid` |
| reqAddr | input | 32 | Request start byte address |
| reqLen | input | 12 | Request byte length, at least 1 |
| reqClass | input | 2 | Request class |
| txnValid | output | 1 | Transaction valid |
| txnReady | input | 1 | Downstream accepts transaction |
| txnAddr | output | 32 | Transaction byte address |
| txnBytes | output | 8 | Transaction byte count |
| txnKind | output | 2 | Write kind |
| txnPad | output | 1 | Line transaction carries zero-filled padding |
| txnRep | output | 1 | Line transaction repeats the 8-byte completion word |

## Verification
Pieces are tried in three placements, and each placement separates different policies:
- A short piece ending exactly at a line edge, compared with one ending short of the edge, separates end-of-line detection from the other status policies.
- Aligned short pieces, compared with aligned whole lines, separate the padding policies from the whole-line-only policies of the parameter and output classes.
- Misaligned requests that span several lines check the splitter's boundaries and ordering.

Every mode value, including the reserved ones, is applied to the same request so that only the policy field differs between runs. Two further cases are tried: a transaction stalled downstream while its fields are watched, and a policy rewrite while a request is in flight.

// File: rtl/wsel_pkg.sv
package wsel_pkg;

  typedef enum logic [1:0] {
    KIND_PART   = 2'd0,
    KIND_FULL   = 2'd1,
    KIND_INJECT = 2'd2
  } wrKind_e;

  typedef enum logic [1:0] {
    CLS_STATUS = 2'd0,
    CLS_COMPL  = 2'd1,
    CLS_PARAM  = 2'd2,
    CLS_OUTPUT = 2'd3
  } reqClass_e;

  // Packed MSB first: statusMode lands at [1:0], outMode at [6].
  typedef struct packed {
    logic       outMode;
    logic [1:0] parmMode;
    logic [1:0] complMode;
    logic [1:0] statusMode;
  } wrPolicy_t;

  localparam int POLICY_W = $bits(wrPolicy_t);

  // Strobes from control to datapath.
  typedef struct packed {
    logic load;  // capture a new request
    logic step;  // current piece accepted, move on
  } dpStrobe_t;

endpackage

// File: rtl/wsel_cfg.sv
module wsel_cfg
  import wsel_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWrEn,
  input  logic [POLICY_W-1:0] cfgWrData,
  output wrPolicy_t           policy
);

  always_ff @(posedge clk) begin
    if (!rstN)        policy <= '0;
    else if (cfgWrEn) policy <= wrPolicy_t'(cfgWrData);
  end

endmodule

// File: rtl/wsel_ctrl.sv
module wsel_ctrl
  import wsel_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      txnReady,
  input  logic      lastPiece,
  output logic      reqReady,
  output logic      txnValid,
  output dpStrobe_t strb
);

  typedef enum logic {ST_IDLE = 1'b0, ST_BUSY = 1'b1} ctrlState_e;
  ctrlState_e state, stateNext;

  always_comb begin
    reqReady  = (state == ST_IDLE);
    txnValid  = (state == ST_BUSY);
    strb.load = reqReady && reqValid;
    strb.step = txnValid && txnReady;
    stateNext = state;
    unique case (state)
      ST_IDLE: if (reqValid) stateNext = ST_BUSY;
      ST_BUSY: if (txnReady && lastPiece) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // An offered transaction is not withdrawn before it is taken.
  assert_valid_held_R10: assert property (@(posedge clk) disable iff (!rstN)
    txnValid && !txnReady |=> txnValid);

  // An accepted request produces a transaction in the next cycle.
  assert_accept_issues_R10: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> txnValid && !reqReady);

  // A request that is not finished keeps the input closed.
  assert_closed_midreq_R10: assert property (@(posedge clk) disable iff (!rstN)
    txnValid && txnReady && !lastPiece |=> !reqReady);

endmodule

// File: rtl/wsel_dp.sv
module wsel_dp
  import wsel_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 12,
  parameter int LINE_BYTES = 128,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int CNT_W     = OFF_W + 1
)(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic              txnValid,
  input  wrPolicy_t         policy,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [1:0]        reqClass,
  output logic [ADDR_W-1:0] txnAddr,
  output logic [CNT_W-1:0]  txnBytes,
  output logic [1:0]        txnKind,
  output logic              txnPad,
  output logic              txnRep,
  output logic              lastPiece
);

  localparam logic [CNT_W-1:0] LINE_CNT = CNT_W'(LINE_BYTES);

  logic [ADDR_W-1:0] curAddr;
  logic [LEN_W-1:0]  remLen;
  reqClass_e         curCls;
  wrPolicy_t         curPol;

  logic [OFF_W-1:0]  lineOff;
  logic [CNT_W-1:0]  roomLeft;
  logic [CNT_W-1:0]  pieceLen;
  logic              alignedStart;
  logic              wholeLine;
  logic              endsAtEdge;
  wrKind_e           kind;
  logic              rep;

  // Request state: loaded on accept, advanced one piece per handshake.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0;
      remLen  <= '0;
      curCls  <= CLS_STATUS;
      curPol  <= '0;
    end else if (strb.load) begin
      curAddr <= reqAddr;
      remLen  <= reqLen;
      curCls  <= reqClass_e'(reqClass);
      curPol  <= policy;
    end else if (strb.step) begin
      curAddr <= curAddr + ADDR_W'(pieceLen);
      remLen  <= remLen - LEN_W'(pieceLen);
    end
  end

  // Piece geometry within the current line.
  always_comb begin
    lineOff      = curAddr[OFF_W-1:0];
    roomLeft     = LINE_CNT - CNT_W'(lineOff);
    lastPiece    = (remLen <= LEN_W'(roomLeft));
    pieceLen     = lastPiece ? CNT_W'(remLen) : roomLeft;
    alignedStart = (lineOff == '0);
    wholeLine    = alignedStart && (pieceLen == LINE_CNT);
    endsAtEdge   = (pieceLen == roomLeft);
  end

  // Policy decode per class.
  always_comb begin
    kind = KIND_PART;
    rep  = 1'b0;
    unique case (curCls)
      CLS_STATUS: begin
        unique case (curPol.statusMode)
          2'd1:    kind = endsAtEdge ? KIND_INJECT : KIND_PART;
          2'd2:    kind = endsAtEdge ? KIND_FULL   : KIND_PART;
          default: kind = KIND_PART;              // 0 and reserved 3
        endcase
      end
      CLS_COMPL: begin
        unique case (curPol.complMode)
          2'd1:    begin kind = KIND_INJECT; rep = 1'b1; end
          2'd2:    begin kind = KIND_FULL;   rep = 1'b1; end
          default: kind = KIND_PART;              // 0 and reserved 3
        endcase
      end
      CLS_PARAM: begin
        unique case (curPol.parmMode)
          2'd0: kind = wholeLine    ? KIND_FULL   : KIND_PART;
          2'd1: kind = alignedStart ? KIND_FULL   : KIND_PART;
          2'd2: kind = wholeLine    ? KIND_INJECT : KIND_PART;
          2'd3: kind = alignedStart ? KIND_INJECT : KIND_PART;
          default: kind = KIND_PART;
        endcase
      end
      CLS_OUTPUT: begin
        if (curPol.outMode) kind = wholeLine ? KIND_INJECT : KIND_PART;
        else                kind = wholeLine ? KIND_FULL   : KIND_PART;
      end
      default: kind = KIND_PART;
    endcase
  end

  // Transaction fields.
  always_comb begin
    txnKind = kind;
    txnRep  = rep;
    if (kind == KIND_PART) begin
      txnAddr  = curAddr;
      txnBytes = pieceLen;
      txnPad   = 1'b0;
    end else begin
      txnAddr  = {curAddr[ADDR_W-1:OFF_W], OFF_W'(0)};
      txnBytes = LINE_CNT;
      txnPad   = !rep && (pieceLen != LINE_CNT);
    end
  end

  // Line transactions sit on a line base and span the line.
  assert_line_shape_R8: assert property (@(posedge clk) disable iff (!rstN)
    txnValid && (txnKind != KIND_PART) |->
      (txnAddr[OFF_W-1:0] == '0) && (txnBytes == LINE_CNT));

  // A partial piece is non-empty and stays inside one line.
  assert_part_in_line_R2: assert property (@(posedge clk) disable iff (!rstN)
    txnValid && (txnKind == KIND_PART) |->
      (txnBytes != '0) && ((CNT_W+1)'(txnAddr[OFF_W-1:0]) + (CNT_W+1)'(txnBytes)
                           <= (CNT_W+1)'(LINE_BYTES)));

  // After a non-final piece the next one starts on a line boundary.
  assert_next_aligned_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.step && !lastPiece |=> (curAddr[OFF_W-1:0] == '0) && txnValid);

  // Padding and replication never both apply.
  assert_pad_rep_excl_R8: assert property (@(posedge clk) disable iff (!rstN)
    txnValid |-> !(txnPad && txnRep));

  // Replication only appears on completion-class requests.
  assert_rep_class_R4: assert property (@(posedge clk) disable iff (!rstN)
    txnValid && txnRep |-> (curCls == CLS_COMPL));

endmodule

// File: rtl/dma_wr_kind_sel.sv
module dma_wr_kind_sel
  import wsel_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 12,
  parameter int LINE_BYTES = 128,
  localparam int CNT_W     = $clog2(LINE_BYTES) + 1
)(
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWrEn,
  input  logic [POLICY_W-1:0] cfgWrData,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [LEN_W-1:0]    reqLen,
  input  logic [1:0]          reqClass,
  output logic                txnValid,
  input  logic                txnReady,
  output logic [ADDR_W-1:0]   txnAddr,
  output logic [CNT_W-1:0]    txnBytes,
  output logic [1:0]          txnKind,
  output logic                txnPad,
  output logic                txnRep
);

  wrPolicy_t policy;
  dpStrobe_t strb;
  logic      lastPiece;

  wsel_cfg uCfg (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgWrData (cfgWrData),
    .policy    (policy)
  );

  wsel_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .txnReady  (txnReady),
    .lastPiece (lastPiece),
    .reqReady  (reqReady),
    .txnValid  (txnValid),
    .strb      (strb)
  );

  wsel_dp #(
    .ADDR_W     (ADDR_W),
    .LEN_W      (LEN_W),
    .LINE_BYTES (LINE_BYTES)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .txnValid  (txnValid),
    .policy    (policy),
    .reqAddr   (reqAddr),
    .reqLen    (reqLen),
    .reqClass  (reqClass),
    .txnAddr   (txnAddr),
    .txnBytes  (txnBytes),
    .txnKind   (txnKind),
    .txnPad    (txnPad),
    .txnRep    (txnRep),
    .lastPiece (lastPiece)
  );

  // A stalled transaction keeps every field.
  assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    txnValid && !txnReady |=> $stable(txnAddr) && $stable(txnBytes)
                              && $stable(txnKind) && $stable(txnPad) && $stable(txnRep));

endmodule

// File: tb/tb_dma_wr_kind_sel.sv
module tb_dma_wr_kind_sel;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [6:0]  cfgWrData = '0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqAddr = '0;
  logic [11:0] reqLen = '0;
  logic [1:0]  reqClass = '0;
  logic        txnValid;
  logic        txnReady = 1'b0;
  logic [31:0] txnAddr;
  logic [7:0]  txnBytes;
  logic [1:0]  txnKind;
  logic        txnPad;
  logic        txnRep;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_wr_kind_sel dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .reqLen(reqLen), .reqClass(reqClass), .txnValid(txnValid),
    .txnReady(txnReady), .txnAddr(txnAddr), .txnBytes(txnBytes),
    .txnKind(txnKind), .txnPad(txnPad), .txnRep(txnRep)
  );

  task automatic report(input bit ok, input string req, input string msg);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  task automatic cfgWrite(input logic [6:0] v);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrData = v;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic sendReq(input logic [31:0] a, input int len, input logic [1:0] cls);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqLen = 12'(len); reqClass = cls;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic takePiece(input logic [31:0] eAddr, input int eBytes, input int eKind,
                           input bit ePad, input bit eRep, input string req);
    int waitCnt = 0;
    while (!txnValid && waitCnt < 50) begin
      @(negedge clk);
      waitCnt++;
    end
    report(txnValid && !reqReady && txnAddr == eAddr && int'(txnBytes) == eBytes
           && int'(txnKind) == eKind && txnPad == ePad && txnRep == eRep, req,
           $sformatf("got v=%0b rdy=%0b addr=%h bytes=%0d kind=%0d pad=%0b rep=%0b exp addr=%h bytes=%0d kind=%0d pad=%0b rep=%0b",
                     txnValid, reqReady, txnAddr, txnBytes, txnKind, txnPad, txnRep,
                     eAddr, eBytes, eKind, ePad, eRep));
    txnReady = 1'b1;
    @(negedge clk);
    txnReady = 1'b0;
  endtask

  task automatic expectIdle(input string req);
    report(!txnValid && reqReady, req,
           $sformatf("got txnValid=%0b reqReady=%0b exp 0/1", txnValid, reqReady));
  endtask

  // R1: reset state
  task automatic testReset();
    @(negedge clk);
    expectIdle("R1");
  endtask

  // R1, R2, R5: default policy, param mode 0, multi-line split
  task automatic testSplitParam0();
    sendReq(32'h1000, 128, 2'd2);
    takePiece(32'h1000, 128, 1, 0, 0, "R1/R5 whole line full");
    sendReq(32'h1010, 300, 2'd2);
    takePiece(32'h1010, 112, 0, 0, 0, "R2 first piece");
    takePiece(32'h1080, 128, 1, 0, 0, "R2/R5 middle piece");
    takePiece(32'h1100,  60, 0, 0, 0, "R2 tail piece");
    expectIdle("R2 idle after last");
  endtask

  // R3, R8, R9: status modes
  task automatic testStatus();
    cfgWrite(7'h01);
    sendReq(32'h1070, 16, 2'd0);
    takePiece(32'h1000, 128, 2, 1, 0, "R3/R8 status m1 edge inject");
    sendReq(32'h1060, 16, 2'd0);
    takePiece(32'h1060, 16, 0, 0, 0, "R3 status m1 not edge");
    cfgWrite(7'h02);
    sendReq(32'h1070, 16, 2'd0);
    takePiece(32'h1000, 128, 1, 1, 0, "R3 status m2 edge full");
    cfgWrite(7'h00);
    sendReq(32'h1070, 16, 2'd0);
    takePiece(32'h1070, 16, 0, 0, 0, "R3 status m0 partial");
    cfgWrite(7'h03);
    sendReq(32'h1070, 16, 2'd0);
    takePiece(32'h1070, 16, 0, 0, 0, "R9 status reserved");
  endtask

  // R4, R9: completion modes
  task automatic testCompl();
    cfgWrite(7'h00);
    sendReq(32'h2008, 8, 2'd1);
    takePiece(32'h2008, 8, 0, 0, 0, "R4 compl m0");
    cfgWrite(7'h04);
    sendReq(32'h2008, 8, 2'd1);
    takePiece(32'h2000, 128, 2, 0, 1, "R4 compl m1 inject rep");
    cfgWrite(7'h08);
    sendReq(32'h2008, 8, 2'd1);
    takePiece(32'h2000, 128, 1, 0, 1, "R4 compl m2 full rep");
    cfgWrite(7'h0C);
    sendReq(32'h2008, 8, 2'd1);
    takePiece(32'h2008, 8, 0, 0, 0, "R9 compl reserved");
  endtask

  // R5, R6, R8: parameter modes 1..3
  task automatic testParam();
    cfgWrite(7'h10);
    sendReq(32'h3000, 40, 2'd2);
    takePiece(32'h3000, 128, 1, 1, 0, "R5/R8 param m1 aligned pad");
    sendReq(32'h3020, 40, 2'd2);
    takePiece(32'h3020, 40, 0, 0, 0, "R5 param m1 unaligned");
    cfgWrite(7'h20);
    sendReq(32'h3000, 128, 2'd2);
    takePiece(32'h3000, 128, 2, 0, 0, "R6 param m2 whole inject");
    sendReq(32'h3000, 40, 2'd2);
    takePiece(32'h3000, 40, 0, 0, 0, "R6 param m2 short");
    cfgWrite(7'h30);
    sendReq(32'h3000, 40, 2'd2);
    takePiece(32'h3000, 128, 2, 1, 0, "R6/R8 param m3 aligned pad");
    sendReq(32'h3040, 8, 2'd2);
    takePiece(32'h3040, 8, 0, 0, 0, "R6 param m3 unaligned");
  endtask

  // R7, R2: output modes
  task automatic testOutput();
    cfgWrite(7'h00);
    sendReq(32'h4000, 200, 2'd3);
    takePiece(32'h4000, 128, 1, 0, 0, "R7 out m0 full");
    takePiece(32'h4080,  72, 0, 0, 0, "R7 out m0 tail");
    cfgWrite(7'h40);
    sendReq(32'h4000, 200, 2'd3);
    takePiece(32'h4000, 128, 2, 0, 0, "R7 out m1 inject");
    takePiece(32'h4080,  72, 0, 0, 0, "R7 out m1 tail");
    sendReq(32'h4010, 128, 2'd3);
    takePiece(32'h4010, 112, 0, 0, 0, "R7/R2 out misaligned a");
    takePiece(32'h4080,  16, 0, 0, 0, "R7/R2 out misaligned b");
  endtask

  // R11: policy write during a request has no effect on it
  task automatic testSnapshot();
    cfgWrite(7'h01);
    sendReq(32'h1070, 16, 2'd0);
    cfgWrite(7'h00);
    takePiece(32'h1000, 128, 2, 1, 0, "R11 snapshot kept");
    sendReq(32'h1070, 16, 2'd0);
    takePiece(32'h1070, 16, 0, 0, 0, "R11 new policy on next request");
  endtask

  // R10: downstream stall holds the transaction
  task automatic testStall();
    logic [31:0] a0;
    logic [1:0]  k0;
    bit ok = 1'b1;
    cfgWrite(7'h00);
    sendReq(32'h4000, 128, 2'd3);
    a0 = txnAddr; k0 = txnKind;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (!txnValid || reqReady || txnAddr != a0 || txnKind != k0 || txnBytes != 8'd128) ok = 1'b0;
    end
    report(ok, "R10", $sformatf("stall got v=%0b rdy=%0b addr=%h kind=%0d exp 1/0 4000 1",
                                txnValid, reqReady, txnAddr, txnKind));
    takePiece(32'h4000, 128, 1, 0, 0, "R10 taken after stall");
    expectIdle("R10 idle after stall");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testSplitParam0();
    testStatus();
    testCompl();
    testParam();
    testOutput();
    testSnapshot();
    testStall();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not complete, got hung exp done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule